// File: doc/BRIEF.md
# Write-Auto-Precharge Command Legality Checker

This block watches a DDR SDRAM command bus with burst length 4. It remembers every write issued with auto precharge, bank by bank. Each later command is judged by two things: whether it targets the bank that is recovering, and how many clock cycles have passed since that write. The block does not alter the bus. It raises a flag for each illegal command, gives the reason, and shows which banks are still locked by a pending internal precharge.

Call the write with auto precharge cycle 0. A write to the same bank stays legal through cycle 5. A read to the same bank is legal from cycle 4 through 7, the window where a read may interrupt the write under data masking. Activate and precharge to that bank are refused throughout. From cycle 8 on the bank is inside its write-recovery and row-precharge time, and every access to it is refused. That window lasts until cycle `5 + TWR + TRP`, and never ends before cycle 9.

While another bank is between cycles 1 and 4 of its sequence, reads to any other bank are refused. Writes, activates and precharges to those other banks stay legal. A legal same-bank write or read replaces the pending sequence. A write that carries A10 starts the count again at cycle 0. A write without A10, or any read, ends tracking for that bank.

Top module: `wap_legality_monitor`

## Requirements
- R1: The command codes are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge and 5 deselect. Codes 6 and 7 are treated as no-op. No-op and deselect always give `legal_o`=1 and never raise `viol_o`. `legal_o` judges the command presented in the same cycle.
- R2: A legal write with `a10_i`=1 sets `busy_o[bank]` in the next cycle. Reset clears every `busy_o` bit and all tracking.
- R3: For the same bank at cycles 1 to 3, a write with or without A10 is legal. A read is refused with reason 1, and an activate or precharge is refused with reason 3.
- R4: For the same bank at cycles 4 and 5, reads and writes are legal. An activate or precharge is refused with reason 3.
- R5: For the same bank at cycles 6 and 7, a write is refused with reason 2 and a read is legal.
- R6: For the same bank from cycle 8 up to cycle `5+TWR+TRP`-1, every non-idle command is refused with reason 4. After the command of that last cycle, `busy_o` drops and the bank accepts any command.
- R7: While a bank is at cycle 1 to 4, a read to any other bank is refused with reason 1. Writes, activates and precharges to the other banks are legal, and from cycle 5 on every other-bank command is legal.
- R8: A legal same-bank write with A10 restarts that bank at cycle 0. A legal same-bank write without A10, or a legal read, ends tracking of that bank.
- R9: `viol_o` is high for exactly the cycle after an illegal command, with `reason_o` holding that command's reason. Otherwise `viol_o` is 0 and `reason_o` is 0. A refused command leaves all tracking unchanged.
- R10: Each of the four banks keeps its own cycle count. A command to one bank never shifts the count of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | 2 | Target bank |
| a10_i | input | 1 | A10 bit; high on a write selects auto precharge |
| legal_o | output | 1 | Current command is allowed |
| viol_o | output | 1 | One-cycle pulse after an illegal command |
| reason_o | output | 3 | Reason for the violation, 0 when none |
| busy_o | output | 4 | Per-bank auto-precharge tracking active |

## Verification
The hardest case to reach is two banks recovering at once, at different offsets. In that state the same-bank table for one bank and the cross-bank read rule from the other apply to the same command. The bench arms bank 0 and then bank 2 two cycles later. It probes a third bank and bank 2 itself at chosen cycles, so that only the right combination of rules gives the expected verdict. The restart case is reached by re-arming a bank in its legal slot. A read at the cycle where the old sequence would already be idle is then refused only if the count really restarted.

// File: rtl/wap_pkg.sv
package wap_pkg;

    localparam logic [2:0] CMD_NOP  = 3'd0;
    localparam logic [2:0] CMD_ACT  = 3'd1;
    localparam logic [2:0] CMD_RD   = 3'd2;
    localparam logic [2:0] CMD_WR   = 3'd3;
    localparam logic [2:0] CMD_PRE  = 3'd4;
    localparam logic [2:0] CMD_DSL  = 3'd5;

    localparam int AGE_W = 8;
    typedef logic [AGE_W-1:0] age_t;

    // first cycle at which the other-bank read restriction is lifted
    localparam int XBANK_READ_OPEN = 5;
    // first cycle of the internal precharge lockout
    localparam int LOCK_START = 8;

    typedef enum logic [2:0] {
        RSN_NONE     = 3'd0,
        RSN_RD_SLOT  = 3'd1,
        RSN_WR_SLOT  = 3'd2,
        RSN_ROW_BUSY = 3'd3,
        RSN_PRECHG   = 3'd4
    } reason_e;

    typedef struct packed {
        logic    active;
        age_t    age;
    } bank_trk_t;

    function automatic logic is_idle_cmd(input logic [2:0] c);
        return (c == CMD_NOP) || (c == CMD_DSL) || (c > CMD_DSL);
    endfunction

    // verdict for a command addressed to the bank that is recovering
    function automatic reason_e own_bank_verdict(input logic [2:0] c, input age_t a);
        reason_e r;
        r = RSN_NONE;
        if (!is_idle_cmd(c)) begin
            if (a >= age_t'(LOCK_START)) begin
                r = RSN_PRECHG;
            end else begin
                case (c)
                    CMD_ACT, CMD_PRE: r = RSN_ROW_BUSY;
                    CMD_RD:           r = (a <= age_t'(3)) ? RSN_RD_SLOT : RSN_NONE;
                    CMD_WR:           r = (a >= age_t'(6)) ? RSN_WR_SLOT : RSN_NONE;
                    default:          r = RSN_NONE;
                endcase
            end
        end
        return r;
    endfunction

    // verdict for a command addressed to a bank other than the recovering one
    function automatic reason_e cross_bank_verdict(input logic [2:0] c, input age_t a);
        if (c == CMD_RD && a < age_t'(XBANK_READ_OPEN))
            return RSN_RD_SLOT;
        return RSN_NONE;
    endfunction

endpackage

// File: rtl/wap_bank_tracker.sv
module wap_bank_tracker
    import wap_pkg::*;
#(
    parameter int CLEAR_AGE = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      arm,
    input  logic      cancel,
    output bank_trk_t trk
);
    localparam age_t LAST_AGE = age_t'(CLEAR_AGE - 1);

    bank_trk_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (arm) begin
            st.active <= 1'b1;
            st.age    <= age_t'(1);
        end else if (cancel) begin
            st <= '0;
        end else if (st.active) begin
            if (st.age == LAST_AGE) begin
                st <= '0;
            end else begin
                st.age <= st.age + age_t'(1);
            end
        end
    end

    assign trk = st;
endmodule

// File: rtl/wap_cmd_judge.sv
module wap_cmd_judge
    import wap_pkg::*;
#(
    parameter int NBANK  = 4,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  bank_trk_t         trk [NBANK],
    output reason_e           verdict
);
    reason_e own_r   [NBANK];
    reason_e cross_r [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_per_bank
        always_comb begin
            own_r[b]   = RSN_NONE;
            cross_r[b] = RSN_NONE;
            if (trk[b].active) begin
                if (bank == BANK_W'(b))
                    own_r[b] = own_bank_verdict(cmd, trk[b].age);
                else
                    cross_r[b] = cross_bank_verdict(cmd, trk[b].age);
            end
        end
    end

    always_comb begin
        reason_e own_sel;
        reason_e cross_sel;
        own_sel   = RSN_NONE;
        cross_sel = RSN_NONE;
        for (int b = 0; b < NBANK; b++) begin
            if (own_r[b] != RSN_NONE)   own_sel   = own_r[b];
            if (cross_r[b] != RSN_NONE) cross_sel = cross_r[b];
        end
        verdict = (own_sel != RSN_NONE) ? own_sel : cross_sel;
    end
endmodule

// File: rtl/wap_legality_monitor.sv
module wap_legality_monitor
    import wap_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int TWR   = 2,
    parameter int TRP   = 3,
    localparam int BANK_W    = $clog2(NBANK),
    localparam int WIN_END   = 5 + TWR + TRP,
    localparam int CLEAR_AGE = (WIN_END > LOCK_START + 1) ? WIN_END : LOCK_START + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              a10_i,
    output logic              legal_o,
    output logic              viol_o,
    output logic [2:0]        reason_o,
    output logic [NBANK-1:0]  busy_o
);
    bank_trk_t trk [NBANK];
    reason_e   verdict;
    logic      ok;
    logic      is_wr_ap;
    logic      is_plain_access;

    wap_cmd_judge #(.NBANK(NBANK)) u_judge (
        .cmd     (cmd_i),
        .bank    (bank_i),
        .trk     (trk),
        .verdict (verdict)
    );

    assign ok              = (verdict == RSN_NONE);
    assign is_wr_ap        = (cmd_i == CMD_WR) && a10_i;
    assign is_plain_access = (cmd_i == CMD_RD) || ((cmd_i == CMD_WR) && !a10_i);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = ok && (bank_i == BANK_W'(b));

        wap_bank_tracker #(.CLEAR_AGE(CLEAR_AGE)) u_trk (
            .clk    (clk),
            .rst    (rst),
            .arm    (hit && is_wr_ap),
            .cancel (hit && is_plain_access),
            .trk    (trk[b])
        );
        assign busy_o[b] = trk[b].active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_o   <= 1'b0;
            reason_o <= 3'd0;
        end else begin
            viol_o   <= !ok;
            reason_o <= verdict;
        end
    end

    assign legal_o = ok;
endmodule

// File: rtl/wap_checker.sv
module wap_checker
    import wap_pkg::*;
#(
    parameter int NBANK = 4,
    localparam int BANK_W = $clog2(NBANK)
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cmd_i,
    input logic [BANK_W-1:0] bank_i,
    input logic              a10_i,
    input logic              legal_o,
    input logic              viol_o,
    input logic [2:0]        reason_o,
    input logic [NBANK-1:0]  busy_o
);
    // R1: idle commands never produce a violation pulse
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (is_idle_cmd(cmd_i) && !$past(rst) ? 1'b1 : 1'b1) && is_idle_cmd(cmd_i) |=> !viol_o);

    // R1: nothing tracked means every command is legal
    a_r1_idle_banks_legal: assert property (@(posedge clk) disable iff (rst)
        (busy_o == '0) |-> legal_o);

    // R2: a legal write with A10 marks its bank busy
    a_r2_arm_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (legal_o && cmd_i == CMD_WR && a10_i) |=> busy_o[$past(bank_i)]);

    // R2: reset leaves every bank idle
    a_r2_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (busy_o == '0 && !viol_o));

    // R3: activate to a busy bank is never legal
    a_r3_act_busy_refused: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_ACT && busy_o[bank_i]) |-> !legal_o);

    // R9: pulse follows the verdict one cycle later
    a_r9_pulse_tracks_verdict: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (viol_o == !$past(legal_o)));

    // R9: reason is nonzero exactly when a violation is flagged
    a_r9_reason_consistent: assert property (@(posedge clk) disable iff (rst)
        viol_o == (reason_o != 3'd0));

    // R9: a refused command leaves the busy set unchanged or only ageing out
    a_r9_refused_no_arm: assert property (@(posedge clk) disable iff (rst)
        (!legal_o && !busy_o[bank_i]) |=> !busy_o[$past(bank_i)]);
endmodule

bind wap_legality_monitor wap_checker #(.NBANK(NBANK)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_i    (cmd_i),
    .bank_i   (bank_i),
    .a10_i    (a10_i),
    .legal_o  (legal_o),
    .viol_o   (viol_o),
    .reason_o (reason_o),
    .busy_o   (busy_o)
);

// File: tb/tb_wap_legality_monitor.sv
`timescale 1ns/1ps
module tb_wap_legality_monitor;
    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, DSL = 3'd5;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] cmd_i;
    logic [1:0] bank_i;
    logic       a10_i;
    logic       legal_o;
    logic       viol_o;
    logic [2:0] reason_o;
    logic [3:0] busy_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic       s_legal;
    logic       s_viol;
    logic [2:0] s_rsn;
    logic [3:0] s_busy;

    always #2.5 clk = ~clk;

    wap_legality_monitor dut (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .a10_i(a10_i),
        .legal_o(legal_o), .viol_o(viol_o), .reason_o(reason_o), .busy_o(busy_o)
    );

    task automatic check(input logic cond, input string req, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one command for one cycle, capture verdict and registered outputs
    task automatic step(input logic [2:0] c, input logic [1:0] b, input logic a);
        @(negedge clk);
        cmd_i = c; bank_i = b; a10_i = a;
        #1;
        s_legal = legal_o;
        @(posedge clk);
        #1;
        s_viol = viol_o; s_rsn = reason_o; s_busy = busy_o;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(NOP, 2'd0, 1'b0);
    endtask

    task automatic expect_verdict(input string req, input logic el, input int er);
        check(s_legal == el, req, s_legal, el);
        check(s_viol == !el, req, s_viol, !el);
        check(int'(s_rsn) == er, req, s_rsn, er);
    endtask

    // arm bank 0 at cycle 0, present a command at cycle k, then drain
    task automatic probe(input string req, input int k, input logic [2:0] c,
                         input logic [1:0] b, input logic a, input logic el, input int er);
        step(WR, 2'd0, 1'b1);
        idle(k - 1);
        step(c, b, a);
        expect_verdict(req, el, er);
        idle(12);
    endtask

    task automatic t_reset;
        rst = 1'b1; cmd_i = NOP; bank_i = 0; a10_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check(busy_o == 4'd0, "R2 reset busy", busy_o, 0);
        check(viol_o == 1'b0, "R2 reset viol", viol_o, 0);
    endtask

    task automatic t_arm_and_idle_cmds;
        step(WR, 2'd1, 1'b1);
        check(s_busy == 4'b0010, "R2 arm busy", s_busy, 2);
        step(DSL, 2'd1, 1'b0);
        expect_verdict("R1 deselect", 1'b1, 0);
        step(3'd7, 2'd1, 1'b1);
        expect_verdict("R1 code7", 1'b1, 0);
        idle(12);
        step(WR, 2'd2, 1'b0);
        check(s_busy == 4'd0, "R2 plain write no arm", s_busy, 0);
        idle(2);
    endtask

    task automatic t_same_bank_table;
        probe("R3 write c3",   3, WR,  2'd0, 1'b0, 1'b1, 0);
        probe("R3 read c2",    2, RD,  2'd0, 1'b0, 1'b0, 1);
        probe("R3 act c3",     3, ACT, 2'd0, 1'b0, 1'b0, 3);
        probe("R3 pre c1",     1, PRE, 2'd0, 1'b1, 1'b0, 3);
        probe("R4 read c4",    4, RD,  2'd0, 1'b1, 1'b1, 0);
        probe("R4 write c5",   5, WR,  2'd0, 1'b1, 1'b1, 0);
        probe("R4 pre c5",     5, PRE, 2'd0, 1'b0, 1'b0, 3);
        probe("R5 write c6",   6, WR,  2'd0, 1'b0, 1'b0, 2);
        probe("R5 read c7",    7, RD,  2'd0, 1'b0, 1'b1, 0);
        probe("R6 write c8",   8, WR,  2'd0, 1'b1, 1'b0, 4);
        probe("R1 nop c8",     8, NOP, 2'd0, 1'b0, 1'b1, 0);
        probe("R6 act c9",     9, ACT, 2'd0, 1'b0, 1'b0, 4);
        probe("R6 act c10",   10, ACT, 2'd0, 1'b0, 1'b1, 0);
    endtask

    task automatic t_cross_bank;
        probe("R7 read b1 c3",  3, RD,  2'd1, 1'b0, 1'b0, 1);
        probe("R7 read b3 c4",  4, RD,  2'd3, 1'b0, 1'b0, 1);
        probe("R7 read b1 c5",  5, RD,  2'd1, 1'b0, 1'b1, 0);
        probe("R7 act b2 c3",   3, ACT, 2'd2, 1'b0, 1'b1, 0);
        probe("R7 write b1 c4", 4, WR,  2'd1, 1'b0, 1'b1, 0);
    endtask

    task automatic t_window_end_and_refusal;
        // refused activate at c3 must not disturb the count (R9)
        step(WR, 2'd0, 1'b1);
        idle(2);
        step(ACT, 2'd0, 1'b0);
        expect_verdict("R9 refused act", 1'b0, 3);
        idle(4);                                   // now at cycle 7
        step(NOP, 2'd0, 1'b0);                     // cycle 8
        check(s_busy[0] == 1'b1, "R6 busy c8", s_busy[0], 1);
        step(NOP, 2'd0, 1'b0);                     // cycle 9
        check(s_busy[0] == 1'b0, "R6 busy drop c9", s_busy[0], 0);
        step(ACT, 2'd0, 1'b0);
        expect_verdict("R6 act after window", 1'b1, 0);
        idle(2);
    endtask

    task automatic t_restart_and_cancel;
        step(WR, 2'd0, 1'b1);                      // c0
        idle(3);
        step(WR, 2'd0, 1'b1);                      // c4 -> new c0
        expect_verdict("R8 rearm legal", 1'b1, 0);
        idle(7);
        step(RD, 2'd0, 1'b0);                      // old c12, new c8
        expect_verdict("R8 restart read c8", 1'b0, 4);
        idle(12);
        step(WR, 2'd0, 1'b1);
        idle(2);
        step(WR, 2'd0, 1'b0);                      // plain write at c3
        check(s_busy[0] == 1'b0, "R8 cancel busy", s_busy[0], 0);
        step(ACT, 2'd0, 1'b0);
        expect_verdict("R8 act after cancel", 1'b1, 0);
        idle(2);
    endtask

    task automatic t_two_banks;
        step(WR, 2'd0, 1'b1);                      // b0 c0
        idle(1);
        step(WR, 2'd2, 1'b1);                      // b0 c2, b2 c0
        check(s_busy == 4'b0101, "R10 two busy", s_busy, 5);
        step(RD, 2'd1, 1'b0);                      // b0 c3, b2 c1
        expect_verdict("R10 read b1 both young", 1'b0, 1);
        idle(4);                                   // b0 c7, b2 c5
        step(RD, 2'd2, 1'b0);                      // b0 c8, b2 c6 read legal
        expect_verdict("R10 read b2 c6", 1'b1, 0);
        check(s_busy == 4'b0001, "R10 b0 still busy", s_busy, 1);
        step(WR, 2'd0, 1'b0);                      // b0 c9
        expect_verdict("R10 b0 c9 locked", 1'b0, 4);
        idle(4);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_arm_and_idle_cmds();
                t_same_bank_table();
                t_cross_bank();
                t_window_end_and_refusal();
                t_restart_and_cancel();
                t_two_banks();
            end
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule